// File: doc/BRIEF.md
# Multiplexed LED Scan Clock Sequencer

This block runs on the host side of a time-multiplexed LED matrix. It sets the timing for the panel's constant-current drivers and their row switches. It produces a grayscale-clock enable, which is one grayscale clock per system cycle while it is high. It also produces one-hot enables for the line-select transistors. A full frame always holds 2^FRAME_BITS grayscale clocks. With the default FRAME_BITS of 16 that is 65536 clocks. The frame is cut into 2^(FRAME_BITS-N) sub-periods of exactly 2^N clocks each, and the lines take turns over these sub-periods. The PWM resolution N is chosen at run time between MIN_BITS and FRAME_BITS. For example, N=10 with 8 lines gives 64 sub-periods, so each line is lit 8 times per frame.

Between two bursts the block can insert a programmable gap. During the gap the grayscale clock is held and every line is off, which gives the row transistors time to switch. A single-line mode leaves line 0 on and runs the grayscale clock without a break. The block raises a one-cycle frame-done pulse once the last clock of each frame has been issued. The resolution, line count, gap length and mode are taken only at frame boundaries.

The controller is built around four states:
- **LOAD** is the one cycle after reset. It samples the configuration.
- **DEAD** is the gap between bursts.
- **BURST** issues the clocks of one sub-period.
- **CONT** is the continuous single-line mode.

Transitions:
- LOAD goes to its entry state: CONT when single mode is selected, DEAD when a gap is programmed, and BURST otherwise.
- DEAD goes to BURST when its countdown reaches its last cycle.
- BURST goes to DEAD at the end of a sub-period when a gap is programmed, and stays in BURST for the next line when no gap is programmed.
- BURST goes to the entry state of the newly sampled configuration at the end of a frame.
- CONT goes to the entry state when its 2^FRAME_BITS counter wraps.

Top module: `led_scan_sequencer`

## Requirements
- R1: In multiplexed mode, each sub-period holds `gsclk_en` high for exactly 2^N consecutive cycles with one line enabled throughout.
- R2: N is taken from `pwm_bits`, clamped up to MIN_BITS and down to FRAME_BITS.
- R3: A frame carries exactly 2^FRAME_BITS grayscale clocks, which is 2^(FRAME_BITS-N) sub-periods in multiplexed mode. `frame_done` is high for one cycle, in the cycle after the frame's last grayscale clock.
- R4: Bit i of `line_en` enables line i. Each frame starts at line 0, and the line moves up by one per sub-period, returning to 0 after line L-1. L is `line_count`, where 0 is treated as 1 and values above MAX_LINES are treated as MAX_LINES.
- R5: `line_en` has exactly one bit set while `gsclk_en` is high, and is all zero while `gsclk_en` is low.
- R6: Between consecutive bursts, including across a frame boundary, `gsclk_en` is low and all lines are off for exactly D = `dead_cycles` cycles. With D = 0, the next line takes over in the first cycle after the previous burst's last clock, and the clock does not pause.
- R7: In single-line mode, `gsclk_en` is high every cycle, only bit 0 of `line_en` is set, and `frame_done` repeats every 2^FRAME_BITS clocks.
- R8: Changes to `pwm_bits`, `line_count`, `dead_cycles` and `single_line` have no effect within a frame. They are sampled at the edge where `frame_done` rises.
- R9: While `rst_n` is low, and in the LOAD cycle that follows reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_bits | input | $clog2(FRAME_BITS+1) | Requested PWM resolution N |
| line_count | input | $clog2(MAX_LINES+1) | Number of scanned lines |
| dead_cycles | input | DEAD_W | Blanking gap length in system cycles |
| single_line | input | 1 | 1 selects continuous single-line mode |
| gsclk_en | output | 1 | Grayscale clock enable, one clock per high cycle |
| line_en | output | MAX_LINES | One-hot line-select enables |
| frame_done | output | 1 | One-cycle pulse after a frame's last clock |

## Verification
The end of a frame and the end of a sub-period always happen in the same cycle. That cycle is also when a new configuration is sampled, so frame completion, line wrap-back and reconfiguration can all collide. The bench sweeps every resolution, line count and gap length of a small configuration, including zero gap, where the line handover and the `frame_done` pulse share a cycle with no pause in the grayscale clock. The bench also changes the configuration in the middle of a frame and switches between modes. It judges each burst length, the line order, each gap length and each frame total against values computed from the configuration that was in force when the frame began.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_DEAD  = 2'd1,
        ST_BURST = 2'd2,
        ST_CONT  = 2'd3
    } scan_state_e;
endpackage

// File: rtl/scan_wrap_counter.sv
// Counter that wraps to zero after reaching a run-time limit.
module scan_wrap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] last_val,
    output logic         at_last
);
    logic [W-1:0] count;

    assign at_last = (count == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= at_last ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/scan_line_decoder.sv
// Index to one-hot line enable, gated by an overall enable.
module scan_line_decoder #(
    parameter int MAX_LINES = 32,
    parameter int IDX_W     = 5
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 en,
    output logic [MAX_LINES-1:0] onehot
);
    for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
        assign onehot[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/led_scan_sequencer.sv
module led_scan_sequencer #(
    parameter int FRAME_BITS = 16,
    parameter int MIN_BITS   = 9,
    parameter int MAX_LINES  = 32,
    parameter int DEAD_W     = 4,
    localparam int NB_W      = $clog2(FRAME_BITS + 1),
    localparam int LCNT_W    = $clog2(MAX_LINES + 1),
    localparam int IDX_W     = $clog2(MAX_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB_W-1:0]      pwm_bits,
    input  logic [LCNT_W-1:0]    line_count,
    input  logic [DEAD_W-1:0]    dead_cycles,
    input  logic                 single_line,
    output logic                 gsclk_en,
    output logic [MAX_LINES-1:0] line_en,
    output logic                 frame_done
);
    import scan_pkg::*;

    scan_state_e state, state_nx, entry_st;

    logic [NB_W-1:0]   cfg_bits, bits_in_c;
    logic [LCNT_W-1:0] cfg_lines, lines_in_c;
    logic [DEAD_W-1:0] cfg_dead, dead_cnt;
    logic              cfg_single;
    logic [IDX_W-1:0]  line_idx;

    logic                  gs_active, gs_at_last, gs_wrap, sub_at_last;
    logic                  burst_end, frame_end, load;
    logic [FRAME_BITS:0]   burst_span, sub_span;
    logic [NB_W-1:0]       sub_shift;
    logic [FRAME_BITS-1:0] burst_last, sub_last, gs_last_val;

    // Clamp the incoming configuration to the supported range.
    always_comb begin
        if (pwm_bits < NB_W'(MIN_BITS))
            bits_in_c = NB_W'(MIN_BITS);
        else if (pwm_bits > NB_W'(FRAME_BITS))
            bits_in_c = NB_W'(FRAME_BITS);
        else
            bits_in_c = pwm_bits;

        if (line_count == '0)
            lines_in_c = LCNT_W'(1);
        else if (line_count > LCNT_W'(MAX_LINES))
            lines_in_c = LCNT_W'(MAX_LINES);
        else
            lines_in_c = line_count;
    end

    // Burst and frame geometry from the latched resolution.
    always_comb begin
        burst_span  = (FRAME_BITS + 1)'(1) << cfg_bits;
        burst_last  = FRAME_BITS'(burst_span - 1'b1);
        sub_shift   = NB_W'(FRAME_BITS) - cfg_bits;
        sub_span    = (FRAME_BITS + 1)'(1) << sub_shift;
        sub_last    = FRAME_BITS'(sub_span - 1'b1);
        gs_last_val = (state == ST_CONT) ? '1 : burst_last;
    end

    // Grayscale clocks within the current burst (or frame in continuous mode).
    scan_wrap_counter #(.W(FRAME_BITS)) u_gs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!gs_active),
        .inc      (gs_active),
        .last_val (gs_last_val),
        .at_last  (gs_at_last)
    );

    // Sub-periods completed within the current frame.
    scan_wrap_counter #(.W(FRAME_BITS)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .inc      (burst_end),
        .last_val (sub_last),
        .at_last  (sub_at_last)
    );

    assign gs_wrap   = gs_active && gs_at_last;
    assign burst_end = (state == ST_BURST) && gs_at_last;
    assign frame_end = (burst_end && sub_at_last) || ((state == ST_CONT) && gs_at_last);
    assign load      = (state == ST_LOAD) || frame_end;

    // Next-state decision.
    always_comb begin
        entry_st = single_line ? ST_CONT :
                   ((dead_cycles != '0) ? ST_DEAD : ST_BURST);
        state_nx = state;
        unique case (state)
            ST_LOAD:  state_nx = entry_st;
            ST_DEAD:  if (dead_cnt == DEAD_W'(1)) state_nx = ST_BURST;
            ST_BURST: if (burst_end)
                          state_nx = sub_at_last ? entry_st :
                                     ((cfg_dead != '0) ? ST_DEAD : ST_BURST);
            ST_CONT:  if (gs_wrap) state_nx = entry_st;
            default:  state_nx = ST_LOAD;
        endcase
    end

    // State register together with the datapath registers it steers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_LOAD;
            cfg_bits   <= NB_W'(FRAME_BITS);
            cfg_lines  <= LCNT_W'(1);
            cfg_dead   <= '0;
            cfg_single <= 1'b0;
            dead_cnt   <= '0;
            line_idx   <= '0;
            frame_done <= 1'b0;
        end else begin
            state      <= state_nx;
            frame_done <= frame_end;
            if (load) begin
                cfg_bits   <= bits_in_c;
                cfg_lines  <= lines_in_c;
                cfg_dead   <= dead_cycles;
                cfg_single <= single_line;
                dead_cnt   <= dead_cycles;
                line_idx   <= '0;
            end else if (burst_end) begin
                dead_cnt <= cfg_dead;
                if ((LCNT_W'(line_idx) + LCNT_W'(1)) == cfg_lines)
                    line_idx <= '0;
                else
                    line_idx <= line_idx + 1'b1;
            end else if (state == ST_DEAD) begin
                dead_cnt <= dead_cnt - 1'b1;
            end
        end
    end

    // Output decode from the state.
    always_comb begin
        gs_active = (state == ST_BURST) || (state == ST_CONT);
        gsclk_en  = gs_active;
    end

    scan_line_decoder #(.MAX_LINES(MAX_LINES), .IDX_W(IDX_W)) u_dec (
        .idx    (line_idx),
        .en     (gs_active),
        .onehot (line_en)
    );

    logic unused_cfg;
    assign unused_cfg = cfg_single;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int MAX_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 gsclk_en,
    input logic [MAX_LINES-1:0] line_en,
    input logic                 frame_done,
    input logic                 gs_wrap
);
    // R5
    line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gsclk_en |-> $onehot(line_en));

    // R5
    lines_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gsclk_en |-> (line_en == '0));

    // R3
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R3
    frame_after_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(gsclk_en));

    // R6
    switch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gsclk_en && $past(gsclk_en) && (line_en != $past(line_en))) |-> $past(gs_wrap));
endmodule

bind led_scan_sequencer scan_seq_chk #(.MAX_LINES(MAX_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gsclk_en   (gsclk_en),
    .line_en    (line_en),
    .frame_done (frame_done),
    .gs_wrap    (gs_wrap)
);

// File: tb/led_scan_sequencer_test.sv
module led_scan_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int F   = 6;
    localparam int MINB = 2;
    localparam int ML  = 4;
    localparam int DW  = 2;
    localparam int NBW = $clog2(F + 1);
    localparam int LCW = $clog2(ML + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NBW-1:0] pwm_bits = '0;
    logic [LCW-1:0] line_count = '0;
    logic [DW-1:0]  dead_cycles = '0;
    logic           single_line = 1'b0;
    logic           gsclk_en;
    logic [ML-1:0]  line_en;
    logic           frame_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_scan_sequencer #(.FRAME_BITS(F), .MIN_BITS(MINB), .MAX_LINES(ML), .DEAD_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_bits(pwm_bits), .line_count(line_count),
        .dead_cycles(dead_cycles), .single_line(single_line),
        .gsclk_en(gsclk_en), .line_en(line_en), .frame_done(frame_done)
    );

    int checks = 0, failures = 0, cycles = 0, frames_seen = 0;
    bit mon_on = 0;

    // Inputs as seen at each rising edge.
    logic [NBW-1:0] s_bits; logic [LCW-1:0] s_lines; logic [DW-1:0] s_dead; logic s_single;
    always @(posedge clk) begin
        s_bits <= pwm_bits; s_lines <= line_count; s_dead <= dead_cycles; s_single <= single_line;
    end

    int exp_n, exp_l, exp_d; bit exp_s;
    bit prev_gs, first_run, fresh;
    logic [ML-1:0] prev_ln, run_ln;
    int run_len, gap, sub_idx, gs_frame;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int clamp_bits(input int v);
        return (v < MINB) ? MINB : ((v > F) ? F : v);
    endfunction

    function automatic int clamp_lines(input int v);
        return (v == 0) ? 1 : ((v > ML) ? ML : v);
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Port monitor: judges bursts, lines, gaps and frames arithmetically.
    always @(negedge clk) begin
        if (mon_on) begin
            automatic bit gs = gsclk_en;
            automatic logic [ML-1:0] ln = line_en;
            automatic bit brk = 0;
            automatic bit old_s;
            if (!exp_s && !fresh) begin
                brk = prev_gs && (!gs || (ln != prev_ln) || frame_done);
                if (brk) begin
                    // R1 burst length
                    check(run_len == (1 << exp_n), "R1 burst length", run_len, 1 << exp_n);
                    // R4 line order
                    check(run_ln == ML'(1 << (sub_idx % exp_l)), "R4 line order",
                          int'(run_ln), 1 << (sub_idx % exp_l));
                    sub_idx++;
                end
            end
            if (frame_done) begin
                frames_seen++;
                // R3 clocks per frame
                check(gs_frame == (1 << F), "R3 clocks per frame", gs_frame, 1 << F);
                if (!exp_s)
                    check(sub_idx == (1 << (F - exp_n)), "R3 sub-periods per frame",
                          sub_idx, 1 << (F - exp_n));
                old_s = exp_s;
                // R8 new settings apply from this boundary
                exp_n = clamp_bits(int'(s_bits));
                exp_l = clamp_lines(int'(s_lines));
                exp_d = int'(s_dead);
                exp_s = s_single;
                if (old_s != exp_s) begin
                    fresh = 1; first_run = 1; gap = 0;
                end
                sub_idx = 0; gs_frame = 0;
            end
            if (exp_s) begin
                // R7 continuous single line
                check(gs && (ln == ML'(1)), "R7 single-line output", int'({gs, ln}), int'({1'b1, ML'(1)}));
                fresh = 0;
            end else begin
                if (gs) begin
                    if (!prev_gs || brk || fresh) begin
                        // R6 gap length
                        if (!first_run) check(gap == exp_d, "R6 gap length", gap, exp_d);
                        run_len = 1; run_ln = ln; gap = 0; first_run = 0;
                    end else begin
                        run_len++;
                    end
                end else begin
                    gap++;
                    // R5 lines dark while clock held
                    check(ln == '0, "R5 lines off in gap", int'(ln), 0);
                end
                fresh = 0;
            end
            if (gs) gs_frame++;
            prev_gs = gs; prev_ln = ln;
        end
    end

    task automatic start_case(input int n, input int l, input int d, input bit s);
        @(negedge clk);
        mon_on = 0;
        rst_n = 1'b0;
        pwm_bits = NBW'(n); line_count = LCW'(l); dead_cycles = DW'(d); single_line = s;
        repeat (2) @(negedge clk);
        // R9 outputs idle in reset
        check(!gsclk_en && line_en == '0 && !frame_done, "R9 reset outputs",
              int'({gsclk_en, line_en, frame_done}), 0);
        exp_n = clamp_bits(n); exp_l = clamp_lines(l); exp_d = d; exp_s = s;
        prev_gs = 0; prev_ln = '0; first_run = 1; fresh = 0;
        run_len = 0; gap = 0; sub_idx = 0; gs_frame = 0; frames_seen = 0;
        rst_n = 1'b1;
        #1;
        // R9 load cycle after release
        check(!gsclk_en && line_en == '0 && !frame_done, "R9 load cycle outputs",
              int'({gsclk_en, line_en, frame_done}), 0);
        mon_on = 1;
    endtask

    task automatic wait_frames(input int k);
        for (int i = 0; i < 4000 && frames_seen < k; i++) @(negedge clk);
        check(frames_seen >= k, "R3 frame completion", frames_seen, k);
    endtask

    initial begin
        // R1 R3 R4 R5 R6: sweep resolution, line count and gap
        for (int n = MINB; n <= F; n++)
            for (int l = 1; l <= ML; l++)
                for (int d = 0; d < (1 << DW); d++)
                    if (!(d == 0 && l == 1 && n < F)) begin
                        start_case(n, l, d, 1'b0);
                        wait_frames(2);
                    end

        // R2 clamping of out-of-range settings
        start_case(0, 0, 1, 1'b0);  wait_frames(2);
        start_case(7, 7, 1, 1'b0);  wait_frames(2);
        start_case(1, 6, 0, 1'b0);  wait_frames(2);

        // R7 single-line mode
        start_case(3, 3, 1, 1'b1);  wait_frames(3);

        // R8 mid-frame changes, including mode switches
        start_case(3, 3, 1, 1'b0);
        repeat (20) @(negedge clk);
        pwm_bits = NBW'(5); line_count = LCW'(2); dead_cycles = DW'(2);
        wait_frames(1);
        repeat (10) @(negedge clk);
        single_line = 1'b1;
        wait_frames(3);
        repeat (17) @(negedge clk);
        single_line = 1'b0; pwm_bits = NBW'(2); line_count = LCW'(4); dead_cycles = DW'(0);
        wait_frames(5);
        repeat (7) @(negedge clk);
        dead_cycles = DW'(3);
        wait_frames(7);

        mon_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule